// File: doc/BRIEF.md
# Butterfly Self-Routing Network

This block moves fixed-format packets from `NUM_PORTS` input lines to the same number of output lines through a butterfly of 2x2 switches. `NUM_PORTS` is a power of two. There are log2 `NUM_PORTS` levels, and each level has `NUM_PORTS`/2 switches. Every packet carries a destination index and a payload. At level i, the switch decides from bit i of the routing tag (source xor destination) whether to pass the packet straight or to swap it onto the partner line. At level i the partner line is the line whose index differs only in bit i. The levels run from bit 0 upward.

Each packet has exactly one path. Each level ends in a register, so every packet spends the same number of cycles in the network whatever its source and destination. A new wave of packets may enter on every cycle. When two packets at one switch want the same output, the packet on the lower-numbered line goes through and the other is discarded. The discarded packet is reported on a per-source flag that rises in the cycle its wave reaches the outputs. Each delivered packet is tagged with the index of the input it came from.

Top module: `bfly_net`

## Requirements
- R1: A valid packet presented on input s in cycle t appears with `outValid` set on output line d (its destination) in cycle t + log2 `NUM_PORTS`, and not in any earlier cycle.
- R2: The payload of a delivered packet is bit-for-bit the payload that was presented.
- R3: `outSrc` of a delivered packet holds the index of the input line it entered on.
- R4: Level i pairs lines whose indices differ only in bit i, and levels are applied from bit 0 upward. When both packets at a switch are valid and want the same output, the packet on the lower-numbered line goes through and the other is removed from the network.
- R5: A removed packet raises `outDrop[s]`, where s is its input index, in the same cycle that its wave reaches the outputs. A packet never both appears on an output and raises its drop flag.
- R6: An input with `inValid` low never produces output, never causes a conflict and never raises a drop flag, whatever its destination field holds.
- R7: When every destination equals the source index xor a common constant, all valid packets are delivered and no drop flag rises.
- R8: Waves presented on consecutive cycles travel independently. Each wave's deliveries and drop flags depend only on that wave.
- R9: While `rstN` is low, and for the following log2 `NUM_PORTS` cycles, `outValid` and `outDrop` are all zero. Packets in flight at reset are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | NUM_PORTS | Per-input packet present |
| inDest | input | NUM_PORTS*log2(NUM_PORTS) | Destination index per input, input k in field k |
| inData | input | NUM_PORTS*DATA_W | Payload per input, input k in field k |
| outValid | output | NUM_PORTS | Per-output packet delivered |
| outSrc | output | NUM_PORTS*log2(NUM_PORTS) | Originating input index per output line |
| outData | output | NUM_PORTS*DATA_W | Delivered payload per output line |
| outDrop | output | NUM_PORTS | Per-source flag: that input's packet was discarded in this wave |

## Verification
The assertions assume that `inValid` is always a known 0 or 1. They also assume that reset is applied before the first packet, because the per-switch conservation and the per-level address-bit checks only count valid lines. Destination and payload fields on idle lines may hold anything, since no assertion looks at them while `inValid` is low. The stimulus drives every input to a defined value on every cycle. It gives idle lines destinations that would collide with a neighbour, so the rule that idle inputs cannot conflict is tested and not merely avoided. It applies reset only at falling clock edges.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Steering strobes produced by the per-level control for one 2x2 switch.
  typedef struct packed {
    logic loValid;   // lower output carries a packet
    logic loTakeHi;  // lower output is fed from the upper-indexed line
    logic hiValid;   // upper output carries a packet
    logic hiTakeLo;  // upper output is fed from the lower-indexed line
    logic dropHi;    // packet on the upper-indexed line lost arbitration
  } swCtl_t;

  // Lower line index of switch sw at level lvl: insert a zero at bit lvl.
  function automatic int loLine(int sw, int lvl);
    return ((sw >> lvl) << (lvl + 1)) | (sw & ((1 << lvl) - 1));
  endfunction

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl #(
  parameter int NUM_PORTS = 8,
  parameter int IDX_W     = 3,
  parameter int LEVEL     = 0
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_PORTS-1:0]                inValid,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0]     inDest,
  output bfly_pkg::swCtl_t [NUM_PORTS/2-1:0]  ctl
);
  localparam int HALF = NUM_PORTS / 2;

  for (genvar sw = 0; sw < HALF; sw++) begin : gSw
    localparam int LO = bfly_pkg::loLine(sw, LEVEL);
    localparam int HI = LO + (1 << LEVEL);

    logic vLo, vHi, wLo, wHi, loClaim, hiClaim;
    assign vLo = inValid[LO];
    assign vHi = inValid[HI];
    // Wanted output side at this level is the destination bit of this level.
    assign wLo = inDest[LO][LEVEL];
    assign wHi = inDest[HI][LEVEL];
    assign loClaim = vLo & ~wLo;   // lower-line packet heads to lower output
    assign hiClaim = vLo &  wLo;   // lower-line packet heads to upper output

    assign ctl[sw] = '{
      loValid:  loClaim | (vHi & ~wHi),
      loTakeHi: ~loClaim,
      hiValid:  hiClaim | (vHi & wHi),
      hiTakeLo: hiClaim,
      dropHi:   vLo & vHi & (wLo == wHi)
    };

    // R4: a lower-line packet always keeps the output it asks for.
    a_r4_lower_keeps_low: assert property (@(posedge clk) disable iff (!rstN)
      (vLo && !wLo) |-> (ctl[sw].loValid && !ctl[sw].loTakeHi));
    a_r4_lower_keeps_high: assert property (@(posedge clk) disable iff (!rstN)
      (vLo && wLo) |-> (ctl[sw].hiValid && ctl[sw].hiTakeLo));
    // R6: a drop needs two valid packets.
    a_r6_drop_needs_pair: assert property (@(posedge clk) disable iff (!rstN)
      ctl[sw].dropHi |-> (vLo && vHi));
    // R5: every valid packet either leaves the switch or is counted as dropped.
    a_r5_conserve: assert property (@(posedge clk) disable iff (!rstN)
      (int'(ctl[sw].loValid) + int'(ctl[sw].hiValid) + int'(ctl[sw].dropHi))
        == (int'(vLo) + int'(vHi)));
  end

endmodule

// File: rtl/bfly_dp.sv
module bfly_dp #(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 3,
  parameter int LEVEL     = 0
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  bfly_pkg::swCtl_t [NUM_PORTS/2-1:0] ctl,
  input  logic [NUM_PORTS-1:0]               inValid,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0]    inDest,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0]    inSrc,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]   inData,
  input  logic [NUM_PORTS-1:0]               inDrop,
  output logic [NUM_PORTS-1:0]               outValid,
  output logic [NUM_PORTS-1:0][IDX_W-1:0]    outDest,
  output logic [NUM_PORTS-1:0][IDX_W-1:0]    outSrc,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]   outData,
  output logic [NUM_PORTS-1:0]               outDrop
);
  localparam int HALF = NUM_PORTS / 2;
  localparam int STEP = 1 << LEVEL;

  logic [NUM_PORTS-1:0]             nValid;
  logic [NUM_PORTS-1:0][IDX_W-1:0]  nDest;
  logic [NUM_PORTS-1:0][IDX_W-1:0]  nSrc;
  logic [NUM_PORTS-1:0][DATA_W-1:0] nData;
  logic [NUM_PORTS-1:0]             nDrop;

  always_comb begin : nextWave
    int lo;
    int hi;
    nValid = '0;
    nDest  = inDest;
    nSrc   = inSrc;
    nData  = inData;
    nDrop  = inDrop;
    for (int s = 0; s < HALF; s++) begin
      lo = bfly_pkg::loLine(s, LEVEL);
      hi = lo + STEP;
      nValid[lo] = ctl[s].loValid;
      nValid[hi] = ctl[s].hiValid;
      nDest[lo]  = ctl[s].loTakeHi ? inDest[hi] : inDest[lo];
      nSrc[lo]   = ctl[s].loTakeHi ? inSrc[hi]  : inSrc[lo];
      nData[lo]  = ctl[s].loTakeHi ? inData[hi] : inData[lo];
      nDest[hi]  = ctl[s].hiTakeLo ? inDest[lo] : inDest[hi];
      nSrc[hi]   = ctl[s].hiTakeLo ? inSrc[lo]  : inSrc[hi];
      nData[hi]  = ctl[s].hiTakeLo ? inData[lo] : inData[hi];
      if (ctl[s].dropHi) nDrop[inSrc[hi]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= '0;
      outDest  <= '0;
      outSrc   <= '0;
      outData  <= '0;
      outDrop  <= '0;
    end else begin
      outValid <= nValid;
      outDest  <= nDest;
      outSrc   <= nSrc;
      outData  <= nData;
      outDrop  <= nDrop;
    end
  end

  // R4: after level LEVEL every valid packet sits on a line whose bit LEVEL
  // matches its destination bit LEVEL.
  for (genvar k = 0; k < NUM_PORTS; k++) begin : gLineChk
    localparam logic KBIT = 1'((k >> LEVEL) & 1);
    a_r4_level_bit: assert property (@(posedge clk) disable iff (!rstN)
      outValid[k] |-> (outDest[k][LEVEL] == KBIT));
  end

  // R6: a fully idle wave adds no drop flags at this level.
  a_r6_idle_no_drop: assert property (@(posedge clk) disable iff (!rstN)
    (inValid == '0) |=> (outDrop == $past(inDrop)));

endmodule

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 8
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [NUM_PORTS-1:0]                    inValid,
  input  logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0]  inDest,
  input  logic [NUM_PORTS*DATA_W-1:0]             inData,
  output logic [NUM_PORTS-1:0]                    outValid,
  output logic [NUM_PORTS*$clog2(NUM_PORTS)-1:0]  outSrc,
  output logic [NUM_PORTS*DATA_W-1:0]             outData,
  output logic [NUM_PORTS-1:0]                    outDrop
);
  localparam int IDX_W  = $clog2(NUM_PORTS);
  localparam int LEVELS = IDX_W;
  localparam int HALF   = NUM_PORTS / 2;

  logic [NUM_PORTS-1:0]             sValid [LEVELS+1];
  logic [NUM_PORTS-1:0][IDX_W-1:0]  sDest  [LEVELS+1];
  logic [NUM_PORTS-1:0][IDX_W-1:0]  sSrc   [LEVELS+1];
  logic [NUM_PORTS-1:0][DATA_W-1:0] sData  [LEVELS+1];
  logic [NUM_PORTS-1:0]             sDrop  [LEVELS+1];

  assign sValid[0] = inValid;
  assign sDest[0]  = inDest;
  assign sData[0]  = inData;
  assign sDrop[0]  = '0;
  for (genvar k = 0; k < NUM_PORTS; k++) begin : gSrcTag
    assign sSrc[0][k] = IDX_W'(k);
  end

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : gLevel
    bfly_pkg::swCtl_t [HALF-1:0] ctl;

    bfly_ctrl #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W), .LEVEL(lvl)) u_ctrl (
      .clk(clk), .rstN(rstN),
      .inValid(sValid[lvl]), .inDest(sDest[lvl]),
      .ctl(ctl)
    );

    bfly_dp #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .IDX_W(IDX_W),
              .LEVEL(lvl)) u_dp (
      .clk(clk), .rstN(rstN), .ctl(ctl),
      .inValid(sValid[lvl]), .inDest(sDest[lvl]), .inSrc(sSrc[lvl]),
      .inData(sData[lvl]), .inDrop(sDrop[lvl]),
      .outValid(sValid[lvl+1]), .outDest(sDest[lvl+1]), .outSrc(sSrc[lvl+1]),
      .outData(sData[lvl+1]), .outDrop(sDrop[lvl+1])
    );
  end

  assign outValid = sValid[LEVELS];
  assign outSrc   = sSrc[LEVELS];
  assign outData  = sData[LEVELS];
  assign outDrop  = sDrop[LEVELS];

  for (genvar k = 0; k < NUM_PORTS; k++) begin : gOutChk
    // R1: a delivered packet sits on the line named by its destination.
    a_r1_on_dest_line: assert property (@(posedge clk) disable iff (!rstN)
      outValid[k] |-> (sDest[LEVELS][k] == IDX_W'(k)));
    // R5: a delivered packet's source is never flagged as dropped.
    a_r5_drop_exclusive: assert property (@(posedge clk) disable iff (!rstN)
      outValid[k] |-> !outDrop[sSrc[LEVELS][k]]);
  end

endmodule

// File: tb/bfly_net_bench.sv
module bfly_net_bench;
  localparam int N   = 8;
  localparam int IW  = 3;
  localparam int DW  = 8;
  localparam int LAT = IW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  inValid = '0;
  logic [N*IW-1:0] inDest = '0;
  logic [N*DW-1:0] inData = '0;
  logic [N-1:0]  outValid;
  logic [N*IW-1:0] outSrc;
  logic [N*DW-1:0] outData;
  logic [N-1:0]  outDrop;

  always #4 clk = ~clk;  // 125 MHz

  bfly_net #(.NUM_PORTS(N), .DATA_W(DW)) u_bfly_net (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest),
    .inData(inData), .outValid(outValid), .outSrc(outSrc),
    .outData(outData), .outDrop(outDrop)
  );

  typedef struct packed {
    logic [N-1:0]    vin;
    logic [N*IW-1:0] dst;
    logic [N-1:0]    vout;
    logic [N*IW-1:0] osrc;
    logic [N-1:0]    drop;
  } vec_t;

  localparam int NV = 8;
  // Fields are listed line 7 down to line 0.
  localparam vec_t VECS [NV] = '{
    // identity, conflict-free (R7)
    '{8'hFF, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'hFF,
             {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h00},
    // dest = src xor 7 (R7)
    '{8'hFF, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 8'hFF,
             {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 8'h00},
    // dest = src xor 5 (R7)
    '{8'hFF, {3'd2,3'd3,3'd0,3'd1,3'd6,3'd7,3'd4,3'd5}, 8'hFF,
             {3'd2,3'd3,3'd0,3'd1,3'd6,3'd7,3'd4,3'd5}, 8'h00},
    // all to 0: only input 0 survives (R4, R5)
    '{8'hFF, 24'h0, 8'h01, 24'h0, 8'hFE},
    // inputs 3 and 5 to 6: meet at level 2, input 3 wins (R4)
    '{8'h28, {3'd0,3'd0,3'd6,3'd0,3'd6,3'd0,3'd0,3'd0}, 8'h40,
             {3'd0,3'd3,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 8'h20},
    // inputs 0 and 1 to 1: level 0 conflict, input 0 wins (R4)
    '{8'h03, {3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd1,3'd1}, 8'h02, 24'h0, 8'h02},
    // input 2 valid to 5, idle input 3 also names 5 (R6)
    '{8'h04, {3'd0,3'd0,3'd0,3'd0,3'd5,3'd5,3'd0,3'd0}, 8'h20,
             {3'd0,3'd0,3'd2,3'd0,3'd0,3'd0,3'd0,3'd0}, 8'h00},
    // nothing valid, garbage destinations (R6)
    '{8'h00, {3'd1,3'd1,3'd1,3'd1,3'd1,3'd1,3'd1,3'd1}, 8'h00, 24'h0, 8'h00}
  };

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [DW-1:0] payload(int wave, int src);
    return DW'((wave * 37 + src * 5 + 3) & 255);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input int wave, input vec_t v);
    inValid = v.vin;
    inDest  = v.dst;
    for (int k = 0; k < N; k++) inData[k*DW +: DW] = payload(wave, k);
  endtask

  task automatic idle();
    inValid = '0;
    inDest  = '1;
    inData  = '1;
  endtask

  task automatic checkWave(input int wave, input vec_t v);
    chk("R1 R7 R8", $sformatf("wave %0d valid", wave), 64'(outValid), 64'(v.vout));
    chk("R5 R4 R6", $sformatf("wave %0d drop", wave), 64'(outDrop), 64'(v.drop));
    for (int k = 0; k < N; k++) begin
      if (v.vout[k]) begin
        chk("R3", $sformatf("wave %0d line %0d src", wave, k),
            64'(outSrc[k*IW +: IW]), 64'(v.osrc[k*IW +: IW]));
        chk("R2", $sformatf("wave %0d line %0d data", wave, k),
            64'(outData[k*DW +: DW]),
            64'(payload(wave, int'(v.osrc[k*IW +: IW]))));
      end
    end
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reset valid", 64'(outValid), 64'h0);
    chk("R9", "reset drop", 64'(outDrop), 64'h0);
    rstN = 1'b1;

    // Streamed table, one wave per cycle (R8)
    for (int cyc = 0; cyc < NV + LAT; cyc++) begin
      @(negedge clk);
      if (cyc >= LAT) checkWave(cyc - LAT, VECS[cyc - LAT]);
      if (cyc < NV) drive(cyc, VECS[cyc]); else idle();
    end

    // R1: exact latency, single packet from input 6 to output 1
    @(negedge clk);
    idle();
    inValid = 8'h40;
    inDest[6*IW +: IW] = 3'd1;
    inData[6*DW +: DW] = 8'hC5;
    for (int c = 1; c <= LAT + 1; c++) begin
      @(negedge clk);
      if (c == 1) idle();
      if (c == LAT - 1) chk("R1", "early output", 64'(outValid), 64'h0);
      if (c == LAT) begin
        chk("R1", "on-time output", 64'(outValid), 64'h02);
        chk("R3", "single src", 64'(outSrc[1*IW +: IW]), 64'd6);
        chk("R2", "single data", 64'(outData[1*DW +: DW]), 64'hC5);
      end
      if (c == LAT + 1) chk("R1", "output gone", 64'(outValid), 64'h0);
    end

    // R9: reset with packets in flight
    @(negedge clk);
    drive(20, VECS[3]);
    @(negedge clk);
    idle();
    rstN = 1'b0;
    #1;
    chk("R9", "in-flight reset valid", 64'(outValid), 64'h0);
    @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < LAT + 1; c++) begin
      @(negedge clk);
      chk("R9", "after reset valid", 64'(outValid), 64'h0);
      chk("R9", "after reset drop", 64'(outDrop), 64'h0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule